// File: doc/BRIEF.md
# Extender Sublayer Fault and Link Status Registers

This block holds the management-visible status of a four-lane 10 Gb/s extender sublayer on the terminal-equipment side. It watches live conditions from the receive and transmit paths: a sync flag per lane, a lane-alignment flag, and two inputs where implementation-specific receive and transmit error detectors report. From these it keeps the status words that a management bus reads.

Four kinds of bit sit side by side. The receive-link-up bit latches low. The receive and transmit local-fault bits latch high. A summary fault bit is the OR of the two latched fault bits. The lane status word is a live, unlatched snapshot. A read strobe with a register address returns the addressed word one cycle later and reloads the latched bits of that word from the live conditions. Link-up and receive-fault sit in different words, so reading one does not touch the other. Because of this, the two need not be inverses of each other at a given moment.

The design takes no part in any datapath. Fault ordered sets that pass through a working link never reach it. Only conditions the sublayer detects itself can set its bits.

Top module: `xgxs_fault_status`

## Requirements
- R1: The live receive-fault condition is true when the alignment flag is 0 or the receive implementation fault input is 1. The live link condition is its inverse. The live transmit-fault condition equals the transmit implementation fault input.
- R2: The link-up bit (status word 1 at address 1, bit 2) latches low. Once the live link condition is 0, it reads 0 until status word 1 is read. That read reloads it with the live link condition.
- R3: The receive and transmit fault bits (status word 2 at address 8, bits 10 and 11) latch high. Once set, each reads 1 until status word 2 is read. That read reloads each with its live condition.
- R4: A read of a fault bit's word in the same cycle as a live fault leaves that bit at 1, so no event is lost.
- R5: The summary fault bit (status word 1, bit 7, and output fault_sum_o) is the OR of the latched receive and transmit fault bits.
- R6: Link-up and receive fault clear on separate reads. After only status word 2 is read, both can read 0 at once.
- R7: The lane status word (address 24) holds the live sync flag of lane n in bit n and the live alignment flag in bit 12. It does not latch, and the implementation fault inputs do not change it.
- R8: rd_data_o changes only on the cycle after a read strobe. It then holds the addressed word as it was before that read's reload. An unused address returns 0.
- R9: During reset, the link-up bit is 0, the fault bits follow their live conditions, and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sync_i | input | NUM_LANES | Live per-lane sync flags |
| align_ok_i | input | 1 | Live lane-alignment flag |
| rx_impl_fault_i | input | 1 | Implementation-specific receive error |
| tx_impl_fault_i | input | 1 | Implementation-specific transmit error |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register address of the read |
| rd_data_o | output | DATA_W | Registered read data |
| link_up_o | output | 1 | Latched-low receive link-up bit |
| rx_fault_o | output | 1 | Latched-high receive fault bit |
| tx_fault_o | output | 1 | Latched-high transmit fault bit |
| fault_sum_o | output | 1 | OR of the latched fault bits |
| lane_stat_o | output | DATA_W | Registered lane status snapshot |

## Verification
The hardest state to reach is the one where link-up and receive fault both read 0. Getting there takes a specific order of steps. First, drop alignment long enough for both latches to capture the event. Then restore it. Then read only status word 2. Reading status word 1 at any point in between would prevent the state. The vector table walks exactly this order.

A second sequence checks that no event is lost when a read and a fault arrive together. It puts a read of status word 2 in the same cycle as a new receive fault, and again as a new transmit fault.

A directed reset with faults present then checks that the fault bits come out of reset already set.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  // Bit positions that management software decodes
  localparam int STAT1_LINK_BIT  = 2;
  localparam int STAT1_FAULT_BIT = 7;
  localparam int STAT2_RXF_BIT   = 10;
  localparam int STAT2_TXF_BIT   = 11;
  localparam int LANE_ALIGN_BIT  = 12;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STAT1 = 2'd1,
    SEL_STAT2 = 2'd2,
    SEL_LANE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xfs_live_cond.sv
module xfs_live_cond (
  input  logic align_ok_i,
  input  logic rx_impl_fault_i,
  input  logic tx_impl_fault_i,
  output logic rx_flt_live_o,
  output logic tx_flt_live_o,
  output logic link_live_o
);
  // Receive fault: loss of alignment or any local receive error
  always_comb begin
    rx_flt_live_o = !align_ok_i || rx_impl_fault_i;
    tx_flt_live_o = tx_impl_fault_i;
    link_live_o   = !rx_flt_live_o;
  end
endmodule

// File: rtl/xfs_latch_bit.sv
module xfs_latch_bit #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic live_i,
  input  logic clr_i,
  output logic q_o
);
  generate
    if (LATCH_HIGH) begin : g_high
      always_ff @(posedge clk) begin
        if (rst)        q_o <= live_i;
        else if (clr_i) q_o <= live_i;
        else            q_o <= q_o | live_i;
      end

      // A set bit stays set until its word is read
      p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
      // A live event always leaves the bit at 1, read or not
      p_no_loss_r4: assert property (@(posedge clk) disable iff (rst)
        live_i |=> q_o);
    end else begin : g_low
      always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (clr_i) q_o <= live_i;
        else            q_o <= q_o & live_i;
      end

      // Link drop always shows as 0 on the next cycle
      p_drop_low_r2: assert property (@(posedge clk) disable iff (rst)
        !live_i |=> !q_o);
      // A cleared bit stays 0 until its word is read
      p_hold_low_r2: assert property (@(posedge clk) disable iff (rst)
        (!q_o && !clr_i) |=> !q_o);
    end
  endgenerate
endmodule

// File: rtl/xfs_lane_snap.sv
module xfs_lane_snap #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic [NUM_LANES-1:0] lane_sync_i,
  input  logic                 align_ok_i,
  output logic [DATA_W-1:0]    word_live_o,
  output logic [DATA_W-1:0]    word_q_o
);
  import xfs_pkg::*;

  always_comb begin
    word_live_o = '0;
    word_live_o[LANE_ALIGN_BIT] = align_ok_i;
  end

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      always_ff @(posedge clk) word_q_o[gl] <= lane_sync_i[gl];
    end
    for (gl = NUM_LANES; gl < DATA_W; gl++) begin : g_rest
      if (gl == LANE_ALIGN_BIT) begin : g_al
        always_ff @(posedge clk) word_q_o[gl] <= align_ok_i;
      end else begin : g_zero
        always_ff @(posedge clk) word_q_o[gl] <= 1'b0;
      end
    end
  endgenerate

  // Snapshot never latches: it tracks alignment one cycle later
  p_lane_live_r7: assert property (@(posedge clk)
    ##1 (word_q_o[LANE_ALIGN_BIT] == $past(align_ok_i)));
endmodule

// File: rtl/xfs_read_port.sv
module xfs_read_port #(
  parameter int NUM_LANES  = 4,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ADDR_STAT1 = 1,
  parameter int ADDR_STAT2 = 8,
  parameter int ADDR_LANE  = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_stb_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 link_q_i,
  input  logic                 rxf_q_i,
  input  logic                 txf_q_i,
  input  logic [NUM_LANES-1:0] lane_sync_i,
  input  logic [DATA_W-1:0]    lane_word_i,
  output logic                 clr_stat1_o,
  output logic                 clr_stat2_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  import xfs_pkg::*;

  reg_sel_e              sel;
  logic [DATA_W-1:0]     word;

  always_comb begin
    if      (rd_addr_i == ADDR_W'(ADDR_STAT1)) sel = SEL_STAT1;
    else if (rd_addr_i == ADDR_W'(ADDR_STAT2)) sel = SEL_STAT2;
    else if (rd_addr_i == ADDR_W'(ADDR_LANE))  sel = SEL_LANE;
    else                                       sel = SEL_NONE;
    clr_stat1_o = rd_stb_i && (sel == SEL_STAT1);
    clr_stat2_o = rd_stb_i && (sel == SEL_STAT2);
  end

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_STAT1: begin
        word[STAT1_LINK_BIT]  = link_q_i;
        word[STAT1_FAULT_BIT] = rxf_q_i | txf_q_i;
      end
      SEL_STAT2: begin
        word[STAT2_RXF_BIT] = rxf_q_i;
        word[STAT2_TXF_BIT] = txf_q_i;
      end
      SEL_LANE: begin
        word = lane_word_i;
        word[NUM_LANES-1:0] = lane_sync_i;
      end
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= word;
  end

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_data_o));
  p_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && sel == SEL_STAT1) |=>
      rd_data_o[STAT1_FAULT_BIT] == ($past(rxf_q_i) | $past(txf_q_i)));
  p_reset_rd_r9: assert property (@(posedge clk)
    rst |=> rd_data_o == '0);
endmodule

// File: rtl/xgxs_fault_status.sv
module xgxs_fault_status #(
  parameter int NUM_LANES  = 4,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ADDR_STAT1 = 1,
  parameter int ADDR_STAT2 = 8,
  parameter int ADDR_LANE  = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lane_sync_i,
  input  logic                 align_ok_i,
  input  logic                 rx_impl_fault_i,
  input  logic                 tx_impl_fault_i,
  input  logic                 rd_stb_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 link_up_o,
  output logic                 rx_fault_o,
  output logic                 tx_fault_o,
  output logic                 fault_sum_o,
  output logic [DATA_W-1:0]    lane_stat_o
);
  logic rx_live, tx_live, link_live;
  logic clr1, clr2;
  logic [DATA_W-1:0] lane_live;

  xfs_live_cond u_cond (
    .align_ok_i      (align_ok_i),
    .rx_impl_fault_i (rx_impl_fault_i),
    .tx_impl_fault_i (tx_impl_fault_i),
    .rx_flt_live_o   (rx_live),
    .tx_flt_live_o   (tx_live),
    .link_live_o     (link_live)
  );

  xfs_latch_bit #(.LATCH_HIGH(1'b0)) u_link (
    .clk(clk), .rst(rst), .live_i(link_live), .clr_i(clr1), .q_o(link_up_o));
  xfs_latch_bit #(.LATCH_HIGH(1'b1)) u_rxf (
    .clk(clk), .rst(rst), .live_i(rx_live), .clr_i(clr2), .q_o(rx_fault_o));
  xfs_latch_bit #(.LATCH_HIGH(1'b1)) u_txf (
    .clk(clk), .rst(rst), .live_i(tx_live), .clr_i(clr2), .q_o(tx_fault_o));

  xfs_lane_snap #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_lane (
    .clk         (clk),
    .lane_sync_i (lane_sync_i),
    .align_ok_i  (align_ok_i),
    .word_live_o (lane_live),
    .word_q_o    (lane_stat_o)
  );

  xfs_read_port #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_STAT1(ADDR_STAT1), .ADDR_STAT2(ADDR_STAT2), .ADDR_LANE(ADDR_LANE)
  ) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_stb_i    (rd_stb_i),
    .rd_addr_i   (rd_addr_i),
    .link_q_i    (link_up_o),
    .rxf_q_i     (rx_fault_o),
    .txf_q_i     (tx_fault_o),
    .lane_sync_i (lane_sync_i),
    .lane_word_i (lane_live),
    .clr_stat1_o (clr1),
    .clr_stat2_o (clr2),
    .rd_data_o   (rd_data_o)
  );

  assign fault_sum_o = rx_fault_o | tx_fault_o;

  // Loss of alignment must reach the receive fault bit
  p_align_fault_r1: assert property (@(posedge clk) disable iff (rst)
    !align_ok_i |=> rx_fault_o);
  // Link bit held low during reset
  p_reset_link_r9: assert property (@(posedge clk)
    rst |=> !link_up_o);
  // Reading word 2 never touches the link bit
  p_indep_r6: assert property (@(posedge clk) disable iff (rst)
    (clr2 && !link_up_o) |=> !link_up_o);
endmodule

// File: tb/tb_xgxs_fault_status.sv
module tb_xgxs_fault_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] sync_i = 4'hF;
  logic align_i = 1'b1, rxf_i = 1'b0, txf_i = 1'b0, rd_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [15:0] rd_data, lane_stat;
  logic link_o, rxf_o, txf_o, sum_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xgxs_fault_status dut (
    .clk(clk), .rst(rst), .lane_sync_i(sync_i), .align_ok_i(align_i),
    .rx_impl_fault_i(rxf_i), .tx_impl_fault_i(txf_i), .rd_stb_i(rd_i),
    .rd_addr_i(addr_i), .rd_data_o(rd_data), .link_up_o(link_o),
    .rx_fault_o(rxf_o), .tx_fault_o(txf_o), .fault_sum_o(sum_o),
    .lane_stat_o(lane_stat));

  // [31:28] sync [27] align [26] rxf [25] txf [24] rd [23:19] addr
  // [18] link [17] rx [16] tx [15:0] read data
  function automatic logic [31:0] mk(input logic [3:0] s, input logic a,
      input logic rf, input logic tf, input logic rd, input logic [4:0] ad,
      input logic el, input logic er, input logic et, input logic [15:0] d);
    return {s, a, rf, tf, rd, ad, el, er, et, d};
  endfunction

  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    mk(4'hF,1,0,0,0, 0, 0,0,0,16'h0000),  // R2 link stays low before read
    mk(4'hF,1,0,0,1, 1, 1,0,0,16'h0000),  // R2 read reloads link
    mk(4'hF,1,0,0,0, 0, 1,0,0,16'h0000),  // R8 hold
    mk(4'hF,0,0,0,0, 0, 0,1,0,16'h0000),  // R1 align loss
    mk(4'hF,1,0,0,0, 0, 0,1,0,16'h0000),  // R2 R3 both latched
    mk(4'hF,1,0,0,1, 8, 0,0,0,16'h0400),  // R6 both read 0
    mk(4'hF,1,0,0,1, 1, 1,0,0,16'h0000),  // R2
    mk(4'hF,1,0,1,0, 0, 1,0,1,16'h0000),  // R1 tx fault
    mk(4'hF,1,0,0,1, 1, 1,0,1,16'h0084),  // R5 summary bit 7
    mk(4'hF,1,1,0,1, 8, 0,1,0,16'h0800),  // R4 read plus rx event
    mk(4'hF,1,1,0,1,24, 0,1,0,16'h100F),  // R7 impl fault not in lane word
    mk(4'h5,0,0,0,1,24, 0,1,0,16'h0005),  // R7 live sync and align
    mk(4'hF,1,0,0,1, 8, 0,0,0,16'h0400),  // R3 read reloads
    mk(4'hF,1,0,0,1, 1, 1,0,0,16'h0000),  // R2
    mk(4'hF,1,0,0,1, 3, 1,0,0,16'h0000),  // R8 unused address
    mk(4'hF,1,0,1,1, 8, 1,0,1,16'h0000)   // R4 read plus tx event
  };

  task automatic chk(input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic el, input logic er,
                           input logic et, input logic [15:0] ed);
    chk({tag, " R2 link"}, {15'd0, link_o}, {15'd0, el});
    chk({tag, " R3 rx"},   {15'd0, rxf_o},  {15'd0, er});
    chk({tag, " R3 tx"},   {15'd0, txf_o},  {15'd0, et});
    chk({tag, " R5 sum"},  {15'd0, sum_o},  {15'd0, er | et});
    chk({tag, " R8 rd"},   rd_data, ed);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state, R9
    chk_state("R9 reset", 1'b0, 1'b0, 1'b0, 16'h0000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {sync_i, align_i, rxf_i, txf_i, rd_i, addr_i} = VEC[i][31:19];
      @(posedge clk);
      @(negedge clk);
      chk_state($sformatf("vec%0d", i), VEC[i][18], VEC[i][17], VEC[i][16],
                VEC[i][15:0]);
      chk($sformatf("vec%0d R7 lane", i), lane_stat,
          {3'b0, VEC[i][27], 8'b0, VEC[i][31:28]});
    end
    // R9: faults present during reset show at once
    rd_i = 1'b0; rst = 1'b1; align_i = 1'b0; txf_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_state("R9 reset with faults", 1'b0, 1'b1, 1'b1, 16'h0000);
    rst = 1'b0; rd_i = 1'b1; addr_i = 5'd1;
    @(posedge clk);
    @(negedge clk);
    chk_state("R5 after reset", 1'b0, 1'b1, 1'b1, 16'h0080);
    rd_i = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule